// File: doc/BRIEF.md
# Key-matching content-addressable memory

This block is a small content-addressable memory. Each numbered slot holds one 64-bit key. A search presents a key and, one clock later, the block reports whether some slot holds that key and which slot it is. A controller that tracks get, set and delete requests sits above the block. It picks the slot for each new key and keeps any values elsewhere.

A write is a single strobe that carries a key and a slot number. The write then takes a fixed number of cycles to finish, and a busy output stays high for that whole time. While busy is high, the block ignores both new write strobes and search requests. A key of all zeros marks a slot as empty. To clear a slot, write zero into it. A search for zero never reports a hit, so an empty slot is never found.

Top module: `key_cam`

## Requirements
- R1: After reset, busy_o and match_o are low, match_addr_o is zero, and every slot holds zero, so no search with a nonzero key reports a hit.
- R2: A search is requested by raising srch_vld_i for one cycle with srch_key_i applied. In the next cycle, match_o is high exactly when some slot holds that key, and match_addr_o gives that slot. Whenever match_o is low, match_addr_o is zero.
- R3: A one-cycle pulse on wr_en_i while busy_o is low starts a write of wr_key_i into slot wr_addr_i. busy_o goes high in the next cycle and stays high for exactly WR_LAT cycles (16 by default). The new key is visible to any search requested after busy_o falls.
- R4: A wr_en_i pulse while busy_o is high has no effect. It changes no slot and does not lengthen the busy window.
- R5: A search requested while busy_o is high is ignored. match_o is low in the cycle after it.
- R6: An all-zero search key never reports a hit, even though empty slots hold zero.
- R7: When several slots hold the searched key, match_addr_o reports the lowest-numbered of them.
- R8: Writing a key into an occupied slot replaces the old key. Writing zero deletes the entry, so its old key is no longer found there.
- R9: When srch_vld_i is low, match_o is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | One-cycle write strobe |
| wr_key_i | input | KEY_W | Key to store |
| wr_addr_i | input | ADDR_W | Target slot, ADDR_W = clog2(SLOTS) |
| busy_o | output | 1 | High while a write is in progress |
| srch_vld_i | input | 1 | Search request |
| srch_key_i | input | KEY_W | Key to search for |
| match_o | output | 1 | Search hit, one cycle after the request |
| match_addr_o | output | ADDR_W | Lowest matching slot, zero when there is no hit |

## Verification
The bench builds the block with 16 slots and a write latency of 5 cycles, and keeps the 64-bit key width. With 16 slots, the bench can fill every slot with a distinct key and search each one back, including the first and last slots. The short latency lets it run many write windows. In each window it places stray write strobes and searches inside the busy period and checks them against the reference model. The default 256-slot, 16-cycle configuration uses the same RTL paths and only changes the counter and comparator widths.

// File: rtl/key_cam_pkg.sv
package key_cam_pkg;
  typedef enum logic {
    WR_IDLE = 1'b0,
    WR_WAIT = 1'b1
  } wr_state_e;
endpackage

// File: rtl/key_cam_wr_seq.sv
module key_cam_wr_seq #(
  parameter int KEY_W  = 64,
  parameter int ADDR_W = 8,
  parameter int WR_LAT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [KEY_W-1:0]  wr_key_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              busy_o,
  output logic              commit_o,
  output logic [KEY_W-1:0]  commit_key_o,
  output logic [ADDR_W-1:0] commit_addr_o
);
  import key_cam_pkg::*;

  localparam int CNT_W = (WR_LAT > 1) ? $clog2(WR_LAT) : 1;

  wr_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [KEY_W-1:0]  key_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      cnt_q   <= '0;
      key_q   <= '0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        WR_IDLE: if (wr_en_i) begin
          state_q <= WR_WAIT;
          cnt_q   <= CNT_W'(WR_LAT - 1);
          key_q   <= wr_key_i;
          addr_q  <= wr_addr_i;
        end
        WR_WAIT: begin
          if (cnt_q == '0) state_q <= WR_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= WR_IDLE;
      endcase
    end
  end

  // the store updates at the same edge where busy falls
  assign busy_o        = (state_q == WR_WAIT);
  assign commit_o      = busy_o && (cnt_q == '0);
  assign commit_key_o  = key_q;
  assign commit_addr_o = addr_q;
endmodule

// File: rtl/key_cam_store.sv
module key_cam_store #(
  parameter int KEY_W  = 64,
  parameter int SLOTS  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [KEY_W-1:0]  commit_key_i,
  input  logic [ADDR_W-1:0] commit_addr_i,
  input  logic [KEY_W-1:0]  srch_key_i,
  output logic [SLOTS-1:0]  hit_o
);
  logic key_nz;
  assign key_nz = |srch_key_i;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [KEY_W-1:0] slot_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         slot_q <= '0;
      else if (commit_i && commit_addr_i == ADDR_W'(g))    slot_q <= commit_key_i;
    end

    assign hit_o[g] = key_nz && (slot_q == srch_key_i);
  end
endmodule

// File: rtl/key_cam_prio.sv
module key_cam_prio #(
  parameter int SLOTS  = 256,
  parameter int ADDR_W = 8
) (
  input  logic [SLOTS-1:0]  hit_i,
  output logic              any_o,
  output logic [ADDR_W-1:0] idx_o
);
  // scan downward so the lowest hit is the last one assigned
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        idx_o = ADDR_W'(i);
      end
    end
  end
endmodule

// File: rtl/key_cam.sv
module key_cam #(
  parameter int KEY_W  = 64,
  parameter int SLOTS  = 256,
  parameter int WR_LAT = 16,
  localparam int ADDR_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [KEY_W-1:0]  wr_key_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              busy_o,
  input  logic              srch_vld_i,
  input  logic [KEY_W-1:0]  srch_key_i,
  output logic              match_o,
  output logic [ADDR_W-1:0] match_addr_o
);
  logic              commit;
  logic [KEY_W-1:0]  commit_key;
  logic [ADDR_W-1:0] commit_addr;
  logic [SLOTS-1:0]  hit;
  logic              any_hit;
  logic [ADDR_W-1:0] hit_idx;

  key_cam_wr_seq #(.KEY_W(KEY_W), .ADDR_W(ADDR_W), .WR_LAT(WR_LAT)) u_wr_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_key_i     (wr_key_i),
    .wr_addr_i    (wr_addr_i),
    .busy_o       (busy_o),
    .commit_o     (commit),
    .commit_key_o (commit_key),
    .commit_addr_o(commit_addr)
  );

  key_cam_store #(.KEY_W(KEY_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit),
    .commit_key_i (commit_key),
    .commit_addr_i(commit_addr),
    .srch_key_i   (srch_key_i),
    .hit_o        (hit)
  );

  key_cam_prio #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_prio (
    .hit_i(hit),
    .any_o(any_hit),
    .idx_o(hit_idx)
  );

  logic srch_ok;
  assign srch_ok = srch_vld_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o      <= 1'b0;
      match_addr_o <= '0;
    end else begin
      match_o      <= srch_ok && any_hit;
      match_addr_o <= (srch_ok && any_hit) ? hit_idx : '0;
    end
  end
endmodule

// File: rtl/key_cam_chk.sv
module key_cam_chk #(
  parameter int KEY_W  = 64,
  parameter int WR_LAT = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              busy_o,
  input logic              srch_vld_i,
  input logic [KEY_W-1:0]  srch_key_i,
  input logic              match_o,
  input logic [ADDR_W-1:0] match_addr_o
);
  localparam int RUN_W = $clog2(WR_LAT + 2);

  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  assert_busy_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_en_i));

  assert_busy_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == RUN_W'(WR_LAT));

  assert_busy_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_W'(WR_LAT));

  assert_search_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(srch_vld_i && !busy_o));

  assert_zero_key_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(srch_key_i) != '0);

  assert_addr_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_o |-> match_addr_o == '0);
endmodule

bind key_cam key_cam_chk #(.KEY_W(KEY_W), .WR_LAT(WR_LAT), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .busy_o      (busy_o),
  .srch_vld_i  (srch_vld_i),
  .srch_key_i  (srch_key_i),
  .match_o     (match_o),
  .match_addr_o(match_addr_o)
);

// File: tb/key_cam_tb_top.sv
`timescale 1ns/1ps
module key_cam_tb_top;
  localparam int KEY_W  = 64;
  localparam int SLOTS  = 16;
  localparam int WR_LAT = 5;
  localparam int ADDR_W = $clog2(SLOTS);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [KEY_W-1:0]  wr_key = '0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic              busy;
  logic              srch_vld = 1'b0;
  logic [KEY_W-1:0]  srch_key = '0;
  logic              match;
  logic [ADDR_W-1:0] match_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  key_cam #(.KEY_W(KEY_W), .SLOTS(SLOTS), .WR_LAT(WR_LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_key_i(wr_key), .wr_addr_i(wr_addr), .busy_o(busy),
    .srch_vld_i(srch_vld), .srch_key_i(srch_key),
    .match_o(match), .match_addr_o(match_addr)
  );

  // reference model
  logic [KEY_W-1:0] m_mem [SLOTS];
  bit               m_busy, m_match;
  int               m_cnt, m_addr, m_waddr;
  logic [KEY_W-1:0] m_wkey;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) m_mem[i] = '0;
      m_busy = 0; m_match = 0; m_cnt = 0; m_addr = 0; m_waddr = 0; m_wkey = '0;
    end else begin
      m_match = 0; m_addr = 0;
      if (srch_vld && !m_busy && srch_key != '0)
        for (int i = SLOTS - 1; i >= 0; i--)
          if (m_mem[i] == srch_key) begin m_match = 1; m_addr = i; end
      if (m_busy) begin
        if (m_cnt == 0) begin m_mem[m_waddr] = m_wkey; m_busy = 0; end
        else m_cnt--;
      end else if (wr_en) begin
        m_busy = 1; m_cnt = WR_LAT - 1; m_wkey = wr_key; m_waddr = int'(wr_addr);
      end
    end
  end

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(busy == m_busy, "R3 busy vs model", busy, m_busy);
    check(match == m_match, "R2 match vs model", match, m_match);
    check(int'(match_addr) == m_addr, "R2 match_addr vs model", match_addr, m_addr);
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_write(logic [KEY_W-1:0] k, int a);
    @(negedge clk);
    wr_en = 1; wr_key = k; wr_addr = ADDR_W'(a);
    @(negedge clk);
    wr_en = 0;
    wait_idle();
  endtask

  task automatic do_search(logic [KEY_W-1:0] k, bit exp_hit, int exp_idx, string tag);
    @(negedge clk);
    srch_vld = 1; srch_key = k;
    @(negedge clk);
    srch_vld = 0;
    check(match == exp_hit, {tag, " hit"}, match, exp_hit);
    check(int'(match_addr) == (exp_hit ? exp_idx : 0), {tag, " index"},
          match_addr, exp_hit ? exp_idx : 0);
  endtask

  function automatic logic [KEY_W-1:0] kgen(int i);
    return {32'hC0DE0000 + 32'(i), 32'h5A5A0000 ^ 32'(i * 7 + 1)};
  endfunction

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(match == 0, "R1 match after reset", match, 0);
    do_search(64'h1234_5678_9ABC_DEF0, 0, 0, "R1 empty search");
    // R9 no request
    @(negedge clk);
    check(match == 0, "R9 idle no match", match, 0);

    // R3 busy window length and visibility
    @(negedge clk);
    wr_en = 1; wr_key = kgen(100); wr_addr = 3;
    @(negedge clk);
    wr_en = 0; n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == WR_LAT, "R3 busy cycles", n, WR_LAT);
    do_search(kgen(100), 1, 3, "R3 key visible");

    // R5 search during busy, R4 strobe during busy
    @(negedge clk);
    wr_en = 1; wr_key = kgen(200); wr_addr = 4;
    @(negedge clk);
    wr_en = 0; srch_vld = 1; srch_key = kgen(100);
    @(negedge clk);
    srch_vld = 0;
    check(match == 0, "R5 search while busy ignored", match, 0);
    wr_en = 1; wr_key = kgen(300); wr_addr = 7;
    @(negedge clk);
    wr_en = 0; n = 2;
    while (busy) begin n++; @(negedge clk); end
    check(n == WR_LAT, "R4 busy not lengthened", n, WR_LAT);
    do_search(kgen(300), 0, 0, "R4 stray write dropped");
    do_search(kgen(200), 1, 4, "R4 first write kept");

    // R6 zero key
    do_search('0, 0, 0, "R6 zero key");

    // R7 lowest index
    do_write(kgen(400), 9);
    do_write(kgen(400), 2);
    do_search(kgen(400), 1, 2, "R7 lowest of two");
    // R8 delete and overwrite
    do_write('0, 2);
    do_search(kgen(400), 1, 9, "R8 deleted slot gone");
    do_write(kgen(500), 9);
    do_search(kgen(400), 0, 0, "R8 overwritten key gone");
    do_search(kgen(500), 1, 9, "R8 new key found");
    do_search('0, 0, 0, "R6 zero key after delete");

    // R2 fill every slot, search all
    for (int i = 0; i < SLOTS; i++) do_write(kgen(i), i);
    for (int i = 0; i < SLOTS; i++) do_search(kgen(i), 1, i, "R2 full table");
    do_search(kgen(SLOTS + 50), 0, 0, "R2 absent key");

    // R5 searches across a busy window against the model
    @(negedge clk);
    wr_en = 1; wr_key = kgen(5); wr_addr = 15;
    @(negedge clk);
    wr_en = 0;
    for (int i = 0; i < WR_LAT + 2; i++) begin
      srch_vld = 1; srch_key = kgen(5);
      @(negedge clk);
    end
    srch_vld = 0;
    wait_idle();
    do_search(kgen(5), 1, 5, "R7 duplicate after window");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule